// File: doc/BRIEF.md
# Line-Paced Video Memory Block Copier

This block moves data from anywhere in the 16-bit address space into the 8 KiB video memory window at `0x8000`–`0x9FFF`. It always moves whole 16-byte blocks. Software sets up five byte-wide registers: a source pointer high and low byte, a destination pointer high and low byte, and a control/status byte. Writing the control byte starts the job. Bit 7 of that write picks the pacing, and bits [6:0] give the number of blocks minus one.

There are two pacings:

- **Bulk pacing** copies every block in one uninterrupted run.
- **Line pacing** copies one block each time the video timing generator signals the start of a horizontal blanking interval.

During any copy the engine raises `cpu_stall`. It uses a read port whose data is valid in the same cycle as the request. It uses a separate write port. Each byte takes a read cycle followed by a write cycle.

After each block the engine writes its running pointers back into the four pointer registers. A later block, or a new job, therefore continues where the last one stopped. The status byte counts the line-paced blocks down and shows `0xFF` when the job is done.

Top module: `vdma_engine`

## Requirements
- R1: After reset the four pointer registers read 0x00, the status register (select 4) reads 0xFF, and `mem_rd_req`, `mem_wr_req` and `cpu_stall` are low.
- R2: The source address used for the first read is {select 0, select 1} with bits [3:0] forced to 0. Each later read increments it by one.
- R3: The first write address is {select 2, select 3} ANDed with 0x1FF0 and then ORed with 0x8000. Each later write increments bits [12:0] only, so 0x9FFF is followed by 0x8000.
- R4: A control write is rejected when the aligned source lies in 0x8000–0x9FFF. A rejected write starts no copy, disarms any armed line pacing, and makes the status read back as the written value with bit 7 set.
- R5: A control write with bit 7 = 0 (and line pacing not armed) copies (bits[6:0]+1)×16 bytes. Each byte takes one read cycle and then one write cycle. `cpu_stall` is high from the cycle after the write through the last write cycle, which is 2 cycles per byte.
- R6: During a bulk job the status reads bits[6:0] of the written value with bit 7 clear. Once the job ends it reads 0xFF.
- R7: A control write with bit 7 = 1 while `lcd_on` and `vid_hblank` are both high arms line pacing and copies one 16-byte block at once.
- R8: Once line pacing is armed, each `hblank_start` pulse seen while `lcd_on` is high and no copy is running copies exactly one 16-byte block. `cpu_stall` is high for 32 cycles.
- R9: After each 16-byte block, the pointer registers read back the next source address and the next destination address.
- R10: In line pacing the status starts as bits[6:0] of the written value and decreases by one after each block. The block that takes it from 0x00 to 0xFF ends line pacing, and later `hblank_start` pulses copy nothing.
- R11: A control write with bit 7 = 1 while `lcd_on` is low starts no copy and leaves line pacing disarmed. The status reads 0x80 | ((value+1) & 0x7F).
- R12: A control write with bit 7 = 0 while line pacing is armed and idle cancels it. No copy starts, the status reads 0x80 | (current status & 0x7F), and later `hblank_start` pulses copy nothing.
- R13: Register writes made while a copy is running are ignored. This covers the cycle in which the block-end bookkeeping happens.
- R14: Each byte written equals the byte returned on `mem_rd_data` in the read cycle just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 src hi, 1 src lo, 2 dst hi, 3 dst lo, 4 control/status |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register (0xFF for selects 5–7) |
| lcd_on | input | 1 | Display enabled |
| vid_hblank | input | 1 | Level: video unit is in horizontal blanking |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blanking |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, valid in the request cycle |
| mem_wr_req | output | 1 | Write request |
| mem_wr_addr | output | 16 | Write address (always in the video window) |
| mem_wr_data | output | 8 | Write data |
| cpu_stall | output | 1 | High while bytes are being moved |

## Verification
The bench aims at the address edges:

- **Unaligned pointers.** A design that skipped the masking would start at the wrong byte, and the scoreboard would see a mismatch on the first write.
- **Destination at `0x9FF0`.** A design that did not wrap inside the window would write to `0xA000`.

It also goes after the status arithmetic, where a wrong design would report a wrong byte or keep copying:

- the countdown through 0x00 to 0xFF;
- the +1 wrap when arming with the display off and a value of 0xFF;
- the cancel path.

Rejected sources, disabled display and register writes during a running copy each check that no stray write reaches the scoreboard and that the pointers were not corrupted.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 7;

  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/vdma_pump.sv
module vdma_pump
  import vdma_pkg::*;
#(
  parameter int BLK_LG  = 4,
  parameter int VRAM_LG = 13,
  parameter int CNT_W   = LEN_W + BLK_LG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_src,
  input  logic [ADDR_W-1:0] go_dst,
  input  logic [CNT_W-1:0]  go_len,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              busy,
  output logic              blk_done,
  output logic              all_done,
  output logic [ADDR_W-1:0] next_src,
  output logic [ADDR_W-1:0] next_dst
);
  phase_t            ph_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  left_q;
  logic [BYTE_W-1:0] byte_q;
  logic              blk_q, fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      byte_q <= '0;
      blk_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      blk_q <= 1'b0;
      fin_q <= 1'b0;
      case (ph_q)
        PH_IDLE: begin
          if (go) begin
            ph_q   <= PH_READ;
            src_q  <= go_src;
            dst_q  <= go_dst;
            left_q <= go_len;
          end
        end
        PH_READ: begin
          byte_q <= rd_data;
          src_q  <= src_q + 1'b1;
          ph_q   <= PH_WRITE;
        end
        PH_WRITE: begin
          dst_q  <= {dst_q[ADDR_W-1:VRAM_LG], dst_q[VRAM_LG-1:0] + 1'b1};
          left_q <= left_q - 1'b1;
          if (left_q[BLK_LG-1:0] == BLK_LG'(1)) blk_q <= 1'b1;
          if (left_q == CNT_W'(1)) begin
            ph_q  <= PH_IDLE;
            fin_q <= 1'b1;
          end else begin
            ph_q <= PH_READ;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign rd_req   = (ph_q == PH_READ);
  assign wr_req   = (ph_q == PH_WRITE);
  assign rd_addr  = src_q;
  assign wr_addr  = dst_q;
  assign wr_data  = byte_q;
  assign busy     = (ph_q != PH_IDLE);
  assign blk_done = blk_q;
  assign all_done = fin_q;
  assign next_src = src_q;
  assign next_dst = dst_q;
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lock,
  input  logic              wb,
  input  logic [ADDR_W-1:0] wb_src,
  input  logic [ADDR_W-1:0] wb_dst,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rdata,
  output logic [ADDR_W-1:0] src_raw,
  output logic [ADDR_W-1:0] dst_raw
);
  localparam int NPTR = 4;

  logic [BYTE_W-1:0] ptr_q  [NPTR];
  logic [BYTE_W-1:0] wb_byte[NPTR];

  assign wb_byte[0] = wb_src[ADDR_W-1:BYTE_W];
  assign wb_byte[1] = wb_src[BYTE_W-1:0];
  assign wb_byte[2] = wb_dst[ADDR_W-1:BYTE_W];
  assign wb_byte[3] = wb_dst[BYTE_W-1:0];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[i] <= '0;
      end else if (wb) begin
        ptr_q[i] <= wb_byte[i];
      end else if (we && !lock && sel == 3'(i)) begin
        ptr_q[i] <= wdata;
      end
    end
  end

  assign src_raw = {ptr_q[0], ptr_q[1]};
  assign dst_raw = {ptr_q[2], ptr_q[3]};

  always_comb begin
    case (sel)
      SEL_SRC_HI: rdata = ptr_q[0];
      SEL_SRC_LO: rdata = ptr_q[1];
      SEL_DST_HI: rdata = ptr_q[2];
      SEL_DST_LO: rdata = ptr_q[3];
      SEL_CTRL:   rdata = status;
      default:    rdata = '1;
    endcase
  end
endmodule

// File: rtl/vdma_ctl.sv
module vdma_ctl
  import vdma_pkg::*;
#(
  parameter int BLK_LG  = 4,
  parameter int VRAM_LG = 13,
  parameter int CNT_W   = LEN_W + BLK_LG + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              lcd_on,
  input  logic              vid_hblank,
  input  logic              hblank_start,
  input  logic [ADDR_W-1:0] src_raw,
  input  logic [ADDR_W-1:0] dst_raw,
  input  logic              pump_busy,
  input  logic              blk_done,
  input  logic              all_done,
  output logic              go,
  output logic [ADDR_W-1:0] go_src,
  output logic [ADDR_W-1:0] go_dst,
  output logic [CNT_W-1:0]  go_len,
  output logic [BYTE_W-1:0] status,
  output logic              lock
);
  localparam int TAG_W = ADDR_W - VRAM_LG;
  localparam logic [TAG_W-1:0] VRAM_TAG = TAG_W'(1) << (TAG_W - 1);
  localparam logic [CNT_W-1:0] BLK_BYTES = CNT_W'(1) << BLK_LG;

  logic              hb_q, gen_q;
  logic [BYTE_W-1:0] st_q;
  logic              ctl_wr, src_bad;

  assign go_src  = {src_raw[ADDR_W-1:BLK_LG], {BLK_LG{1'b0}}};
  assign go_dst  = {VRAM_TAG, dst_raw[VRAM_LG-1:BLK_LG], {BLK_LG{1'b0}}};
  assign src_bad = (go_src[ADDR_W-1:VRAM_LG] == VRAM_TAG);
  assign lock    = pump_busy | gen_q | blk_done;
  assign ctl_wr  = we && (sel == SEL_CTRL) && !lock;
  assign status  = st_q;

  always_comb begin
    go     = 1'b0;
    go_len = BLK_BYTES;
    if (ctl_wr) begin
      if (!src_bad) begin
        if (wdata[BYTE_W-1]) begin
          go = lcd_on && vid_hblank;
        end else if (!hb_q) begin
          go     = 1'b1;
          go_len = (CNT_W'(wdata[LEN_W-1:0]) + CNT_W'(1)) << BLK_LG;
        end
      end
    end else if (hb_q && lcd_on && hblank_start && !lock) begin
      go = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_q  <= 1'b0;
      gen_q <= 1'b0;
      st_q  <= '1;
    end else if (ctl_wr) begin
      if (src_bad) begin
        st_q <= wdata | 8'h80;
        hb_q <= 1'b0;
      end else if (wdata[BYTE_W-1]) begin
        if (!lcd_on) begin
          st_q <= {1'b1, wdata[LEN_W-1:0] + 7'd1};
          hb_q <= 1'b0;
        end else begin
          st_q <= {1'b0, wdata[LEN_W-1:0]};
          hb_q <= 1'b1;
        end
      end else if (hb_q) begin
        hb_q <= 1'b0;
        st_q <= {1'b1, st_q[LEN_W-1:0]};
      end else begin
        gen_q <= 1'b1;
        st_q  <= {1'b0, wdata[LEN_W-1:0]};
      end
    end else if (blk_done) begin
      if (gen_q) begin
        if (all_done) begin
          gen_q <= 1'b0;
          st_q  <= '1;
        end
      end else if (hb_q) begin
        st_q <= st_q - 1'b1;
        if (st_q == '0) hb_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int BLK_LG  = 4,
  parameter int VRAM_LG = 13
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        lcd_on,
  input  logic        vid_hblank,
  input  logic        hblank_start,
  output logic        mem_rd_req,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        mem_wr_req,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        cpu_stall
);
  localparam int CNT_W = LEN_W + BLK_LG + 1;

  logic              go, lock, pump_busy, blk_done, all_done;
  logic [ADDR_W-1:0] go_src, go_dst, src_raw, dst_raw, next_src, next_dst;
  logic [CNT_W-1:0]  go_len;
  logic [BYTE_W-1:0] status;

  vdma_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .lock(lock), .wb(blk_done), .wb_src(next_src), .wb_dst(next_dst),
    .status(status), .rdata(cfg_rdata), .src_raw(src_raw), .dst_raw(dst_raw)
  );

  vdma_ctl #(.BLK_LG(BLK_LG), .VRAM_LG(VRAM_LG), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .lcd_on(lcd_on), .vid_hblank(vid_hblank), .hblank_start(hblank_start),
    .src_raw(src_raw), .dst_raw(dst_raw), .pump_busy(pump_busy),
    .blk_done(blk_done), .all_done(all_done), .go(go), .go_src(go_src),
    .go_dst(go_dst), .go_len(go_len), .status(status), .lock(lock)
  );

  vdma_pump #(.BLK_LG(BLK_LG), .VRAM_LG(VRAM_LG), .CNT_W(CNT_W)) u_pump (
    .clk(clk), .rst(rst), .go(go), .go_src(go_src), .go_dst(go_dst),
    .go_len(go_len), .rd_data(mem_rd_data), .rd_req(mem_rd_req),
    .rd_addr(mem_rd_addr), .wr_req(mem_wr_req), .wr_addr(mem_wr_addr),
    .wr_data(mem_wr_data), .busy(pump_busy), .blk_done(blk_done),
    .all_done(all_done), .next_src(next_src), .next_dst(next_dst)
  );

  assign cpu_stall = pump_busy;
endmodule

// File: rtl/vdma_engine_chk.sv
module vdma_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [2:0]  cfg_sel,
  input logic        lcd_on,
  input logic        hblank_start,
  input logic        mem_rd_req,
  input logic [7:0]  mem_rd_data,
  input logic        mem_wr_req,
  input logic [15:0] mem_wr_addr,
  input logic [7:0]  mem_wr_data,
  input logic        cpu_stall
);
  // R5: one port active per cycle
  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  // R5: every write directly follows a read
  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> $past(mem_rd_req));

  // R5: traffic only under stall
  assert_stall_covers_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> cpu_stall);

  // R3: destination always inside the video window
  assert_dst_window_R3: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> (mem_wr_addr[15:13] == 3'b100));

  // R14: written byte is the byte just read
  assert_wr_data_R14: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> (mem_wr_data == $past(mem_rd_data)));

  // R8, R11: a copy starts only after a control write or an hblank pulse with display on
  assert_start_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_stall) |-> ($past(cfg_we && cfg_sel == 3'd4) || $past(hblank_start && lcd_on)));
endmodule

bind vdma_engine vdma_engine_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .lcd_on(lcd_on),
  .hblank_start(hblank_start), .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data),
  .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .cpu_stall(cpu_stall)
);

// File: tb/vdma_engine_test.sv
module vdma_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        lcd_on = 1'b1;
  logic        vid_hblank = 1'b0;
  logic        hblank_start = 1'b0;
  logic        mem_rd_req, mem_wr_req, cpu_stall;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data, mem_wr_data;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] src_byte(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  assign mem_rd_data = src_byte(mem_rd_addr);

  vdma_engine uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lcd_on(lcd_on), .vid_hblank(vid_hblank),
    .hblank_start(hblank_start), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .cpu_stall(cpu_stall)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // monitor: scoreboard of writes (R2, R3, R14)
  always @(negedge clk) begin
    if (!rst && mem_wr_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected write: actual %0h expected none", {mem_wr_addr, mem_wr_data});
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if ({mem_wr_addr, mem_wr_data} != e) begin
          errors++;
          $display("FAIL R2/R3/R14 write: actual %0h expected %0h", {mem_wr_addr, mem_wr_data}, e);
        end
      end
    end
  end

  // driver side: push expected writes
  task automatic expect_copy(input logic [15:0] src, input logic [15:0] dst, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] s, d;
      s = src + 16'(i);
      d = {3'b100, dst[12:0] + 13'(i)};
      exp_q.push_back({d, src_byte(s)});
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    cfg_sel = s;
    #1 v = cfg_rdata;
  endtask

  task automatic pulse_hb();
    @(negedge clk);
    hblank_start = 1'b1;
    @(negedge clk);
    hblank_start = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (cpu_stall) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle_check(input string req, input int cyc);
    int hits = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (cpu_stall || mem_rd_req) hits++;
    end
    check(hits == 0 && exp_q.size() == 0, req, hits, 0);
  endtask

  task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
    wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd_reg(3'(i), v);
      check(v == 8'h00, "R1 ptr reset", v, 8'h00);
    end
    rd_reg(3'd4, v);
    check(v == 8'hFF, "R1 status reset", v, 8'hFF);
    check(!mem_rd_req && !mem_wr_req && !cpu_stall, "R1 idle outputs",
          {mem_rd_req, mem_wr_req, cpu_stall}, 0);

    // R2 R3 R5 R6 R9: bulk, unaligned pointers
    set_ptrs(16'h1234, 16'hE127);
    expect_copy(16'h1230, 16'h8120, 32);
    wr_reg(3'd4, 8'h01);
    count_stall(n);
    check(n == 64, "R5 stall cycles", n, 64);
    rd_reg(3'd4, v);
    check(v == 8'hFF, "R6 bulk done status", v, 8'hFF);
    check(exp_q.size() == 0, "R2 all bulk writes seen", exp_q.size(), 0);
    rd_reg(3'd0, v); check(v == 8'h12, "R9 src hi", v, 8'h12);
    rd_reg(3'd1, v); check(v == 8'h50, "R9 src lo", v, 8'h50);
    rd_reg(3'd2, v); check(v == 8'h81, "R9 dst hi", v, 8'h81);
    rd_reg(3'd3, v); check(v == 8'h40, "R9 dst lo", v, 8'h40);

    // R3 destination wrap inside the window
    set_ptrs(16'h0400, 16'h1FF0);
    expect_copy(16'h0400, 16'h9FF0, 32);
    wr_reg(3'd4, 8'h01);
    count_stall(n);
    check(n == 64 && exp_q.size() == 0, "R3 wrap copy", n, 64);
    rd_reg(3'd2, v); check(v == 8'h80, "R3 dst hi after wrap", v, 8'h80);

    // R4 rejected source, also disarms armed line pacing
    set_ptrs(16'h2000, 16'h8000);
    wr_reg(3'd4, 8'h81);
    rd_reg(3'd4, v); check(v == 8'h01, "R10 armed status", v, 8'h01);
    wr_reg(3'd0, 8'h88);
    wr_reg(3'd4, 8'h05);
    rd_reg(3'd4, v); check(v == 8'h85, "R4 reject status", v, 8'h85);
    pulse_hb();
    idle_check("R4 no copy after reject", 40);

    // R11 display off
    wr_reg(3'd0, 8'h20);
    lcd_on = 1'b0;
    wr_reg(3'd4, 8'h83);
    rd_reg(3'd4, v); check(v == 8'h84, "R11 status", v, 8'h84);
    wr_reg(3'd4, 8'hFF);
    rd_reg(3'd4, v); check(v == 8'h80, "R11 status wrap", v, 8'h80);
    lcd_on = 1'b1;
    pulse_hb();
    idle_check("R11 no copy", 40);

    // R8 R9 R10 line pacing, three blocks
    wr_reg(3'd4, 8'h82);
    idle_check("R8 waits for hblank", 20);
    rd_reg(3'd4, v); check(v == 8'h02, "R10 initial status", v, 8'h02);
    expect_copy(16'h2000, 16'h8000, 16);
    pulse_hb();
    count_stall(n);
    check(n == 32 && exp_q.size() == 0, "R8 burst 1", n, 32);
    rd_reg(3'd4, v); check(v == 8'h01, "R10 after burst 1", v, 8'h01);
    rd_reg(3'd1, v); check(v == 8'h10, "R9 src lo after burst", v, 8'h10);
    rd_reg(3'd3, v); check(v == 8'h10, "R9 dst lo after burst", v, 8'h10);
    expect_copy(16'h2010, 16'h8010, 16);
    pulse_hb();
    count_stall(n);
    rd_reg(3'd4, v); check(v == 8'h00, "R10 after burst 2", v, 8'h00);
    expect_copy(16'h2020, 16'h8020, 16);
    pulse_hb();
    count_stall(n);
    rd_reg(3'd4, v); check(v == 8'hFF, "R10 wrap ends", v, 8'hFF);
    pulse_hb();
    idle_check("R10 no copy after end", 40);

    // R7 immediate start inside blanking
    vid_hblank = 1'b1;
    expect_copy(16'h2030, 16'h8030, 16);
    wr_reg(3'd4, 8'h80);
    count_stall(n);
    check(n == 32 && exp_q.size() == 0, "R7 immediate burst", n, 32);
    rd_reg(3'd4, v); check(v == 8'hFF, "R7 status", v, 8'hFF);
    vid_hblank = 1'b0;

    // R12 cancel
    wr_reg(3'd4, 8'h85);
    expect_copy(16'h2040, 16'h8040, 16);
    pulse_hb();
    count_stall(n);
    rd_reg(3'd4, v); check(v == 8'h04, "R12 before cancel", v, 8'h04);
    wr_reg(3'd4, 8'h00);
    rd_reg(3'd4, v); check(v == 8'h84, "R12 cancel status", v, 8'h84);
    pulse_hb();
    idle_check("R12 no copy after cancel", 40);

    // R13 writes during a running copy are ignored
    set_ptrs(16'h3000, 16'h0800);
    expect_copy(16'h3000, 16'h8800, 64);
    wr_reg(3'd4, 8'h03);
    wr_reg(3'd0, 8'h77);
    wr_reg(3'd4, 8'h80);
    count_stall(n);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R13 copy complete", exp_q.size(), 0);
    rd_reg(3'd0, v); check(v == 8'h30, "R13 src hi kept", v, 8'h30);
    rd_reg(3'd1, v); check(v == 8'h40, "R13 src lo", v, 8'h40);
    rd_reg(3'd4, v); check(v == 8'hFF, "R13 status", v, 8'hFF);
    idle_check("R13 no extra copy", 20);

    finish_up();
  end
endmodule